// File: doc/BRIEF.md
# Tick Timer with Match and Mode Control

The block is a 32-bit tick counter with a companion control word. The control word holds a 28-bit match period, an interrupt-enable bit, a sticky pending bit and a 2-bit mode. The counter advances by one on every cycle in which the tick strobe is high. When an increment makes the counter's low 28 bits equal to the period, a match occurs. The upper four counter bits play no part in the match.

On a match with interrupt-enable set, the pending bit is set. The interrupt output stays high while both pending and enable are set. The mode then decides what the counter does after the match: restart from zero, stop and hold, or keep counting through the full 32-bit range. In the off mode the counter does not advance, so no match can occur.

Software loads either register through a write strobe per register and a shared data word. Both registers are always visible on dedicated read outputs. A processor uses the block as its periodic or one-shot timer interrupt source.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous reset, the counter and the control word both read zero and `irq` is low.
- R2: When the mode is not off and the counter is not stopped, each cycle with `tick_en` high adds one to the counter. A cycle with `tick_en` low leaves the counter unchanged.
- R3: A match occurs on an increment that makes counter bits 27:0 equal the period in control bits 27:0, whatever counter bits 31:28 hold.
- R4: A match with interrupt-enable (control bit 29) set sets the pending bit (control bit 28). A match with enable clear leaves pending unchanged. `irq` equals pending AND enable.
- R5: Pending is sticky. A control write with bit 28 = 0 clears it. A control write with bit 28 = 1 keeps its current value and never sets it.
- R6: Mode 00 (control bits 31:30) is off: the counter holds its value whatever `tick_en` does.
- R7: Mode 01 is restart. The counter becomes 0 in the cycle of a match and keeps counting from there.
- R8: Mode 10 is one-shot. The counter takes the period value at the match and then holds it, until either register is written.
- R9: Mode 11 is continuous. The counter keeps incrementing through a match and wraps from 0xFFFFFFFF to 0.
- R10: A counter write in the same cycle as an increment or a restart clear wins: the counter takes the written value.
- R11: A control write stores mode, enable and period exactly from bits 31:30, 29 and 27:0 of the write data. The stored word reads back on `mode_o` in the same layout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count strobe, one increment per high cycle |
| cnt_wr | input | 1 | Load the counter from `wr_data` |
| mode_wr | input | 1 | Load the control word from `wr_data` |
| wr_data | input | 32 | Write data for either register |
| count_o | output | 32 | Current counter value |
| mode_o | output | 32 | Current control word |
| irq | output | 1 | Level timer interrupt request |

## Verification
Every result is registered once. A write, a tick or a match shows on `count_o`, `mode_o` and `irq` right after the next rising edge, with no further pipeline delay. The bench drives each stimulus at a falling edge, advances its behavioural model at the following rising edge, and compares all three outputs at the next falling edge, so every comparison falls exactly one cycle after its cause. The corner cases of R3, R9 and R10 are each set up by a counter write followed by a known number of ticks, so the match cycle is known in advance.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int TT_CNT_W = 32;
    localparam int TT_PER_W = 28;

    typedef enum logic [1:0] {
        TT_OFF     = 2'b00,
        TT_RESTART = 2'b01,
        TT_ONESHOT = 2'b10,
        TT_CONT    = 2'b11
    } tt_mode_e;

    typedef struct packed {
        tt_mode_e              mode;
        logic                  ie;
        logic                  ip;
        logic [TT_PER_W-1:0]   period;
    } tt_ctrl_t;

    function automatic tt_ctrl_t tt_unpack(input logic [TT_PER_W+3:0] w);
        tt_ctrl_t c;
        c.mode   = tt_mode_e'(w[TT_PER_W+3:TT_PER_W+2]);
        c.ie     = w[TT_PER_W+1];
        c.ip     = w[TT_PER_W];
        c.period = w[TT_PER_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/tt_match.sv
module tt_match
    import tick_timer_pkg::*;
#(
    parameter int PER_W = TT_PER_W
) (
    input  logic             step,
    input  logic [PER_W-1:0] low_bits,
    input  logic [PER_W-1:0] period,
    output logic             hit
);
    logic [PER_W-1:0] low_next;

    always_comb begin
        low_next = low_bits + PER_W'(1);
        hit      = step && (low_next == period);
    end
endmodule

// File: rtl/tt_counter.sv
module tt_counter
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = TT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             ctrl_load,
    input  logic             step,
    input  logic             hit,
    input  tt_mode_e         mode,
    output logic [CNT_W-1:0] cnt_q,
    output logic             stopped_q
);
    logic [CNT_W-1:0] cnt_d;
    logic             stopped_d;

    always_comb begin
        cnt_d     = cnt_q;
        stopped_d = stopped_q;
        if (load) begin
            cnt_d     = load_val;
            stopped_d = 1'b0;
        end else begin
            if (step) begin
                if (hit && mode == TT_RESTART) cnt_d = '0;
                else                           cnt_d = cnt_q + CNT_W'(1);
            end
            if (ctrl_load)                      stopped_d = 1'b0;
            else if (hit && mode == TT_ONESHOT) stopped_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            stopped_q <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            stopped_q <= stopped_d;
        end
    end
endmodule

// File: rtl/tt_ctrl_reg.sv
module tt_ctrl_reg
    import tick_timer_pkg::*;
#(
    parameter int PER_W = TT_PER_W,
    localparam int W    = PER_W + 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         hit,
    output tt_ctrl_t     ctrl_q
);
    tt_ctrl_t wr_c;
    tt_ctrl_t ctrl_d;

    always_comb begin
        wr_c   = tt_unpack(load_val);
        ctrl_d = ctrl_q;
        if (load) begin
            ctrl_d.mode   = wr_c.mode;
            ctrl_d.ie     = wr_c.ie;
            ctrl_d.period = wr_c.period;
            ctrl_d.ip     = ctrl_q.ip & wr_c.ip;
        end
        if (hit && ctrl_q.ie) ctrl_d.ip = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = TT_CNT_W,
    localparam int PER_W = TT_PER_W,
    localparam int CW    = PER_W + 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             cnt_wr,
    input  logic             mode_wr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic [CW-1:0]    mode_o,
    output logic             irq
);
    tt_ctrl_t ctrl;
    logic     stopped;
    logic     step;
    logic     hit;

    assign step = tick_en && (ctrl.mode != TT_OFF) && !stopped;

    tt_match #(.PER_W(PER_W)) u_match (
        .step     (step),
        .low_bits (count_o[PER_W-1:0]),
        .period   (ctrl.period),
        .hit      (hit)
    );

    tt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .load      (cnt_wr),
        .load_val  (wr_data),
        .ctrl_load (mode_wr),
        .step      (step),
        .hit       (hit),
        .mode      (ctrl.mode),
        .cnt_q     (count_o),
        .stopped_q (stopped)
    );

    tt_ctrl_reg #(.PER_W(PER_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .load     (mode_wr),
        .load_val (wr_data[CW-1:0]),
        .hit      (hit),
        .ctrl_q   (ctrl)
    );

    assign mode_o = ctrl;
    assign irq    = ctrl.ip & ctrl.ie;
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker (
    input logic        clk,
    input logic        rst,
    input logic        tick_en,
    input logic        cnt_wr,
    input logic        mode_wr,
    input logic [31:0] wr_data,
    input logic [31:0] count_o,
    input logic [31:0] mode_o,
    input logic        irq
);
    logic [27:0] low_inc;
    assign low_inc = count_o[27:0] + 28'd1;

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (count_o == 32'd0 && mode_o == 32'd0 && !irq));

    assert_off_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_o[31:30] == 2'b00 && !cnt_wr) |=> $stable(count_o));

    assert_no_pend_without_en_R4: assert property (@(posedge clk) disable iff (rst)
        (!mode_o[28] && !mode_o[29]) |=> !mode_o[28]);

    assert_irq_needs_en_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mode_o[29] && mode_o[28]));

    assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_o[28] && !mode_wr) |=> mode_o[28]);

    assert_restart_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_o[31:30] == 2'b01 && tick_en && !cnt_wr && !mode_wr
         && low_inc == mode_o[27:0]) |=> (count_o == 32'd0));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (count_o == $past(wr_data)));
endmodule

bind tick_timer tick_timer_checker u_tick_timer_checker (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .cnt_wr  (cnt_wr),
    .mode_wr (mode_wr),
    .wr_data (wr_data),
    .count_o (count_o),
    .mode_o  (mode_o),
    .irq     (irq)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        cnt_wr = 1'b0;
    logic        mode_wr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] count_o;
    logic [31:0] mode_o;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference state
    logic [31:0] m_cnt = '0;
    logic [27:0] m_per = '0;
    logic [1:0]  m_mode = '0;
    logic        m_ie = 0, m_ip = 0, m_halt = 0;

    always #5 clk = ~clk;

    tick_timer u_tick_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_wr(cnt_wr),
        .mode_wr(mode_wr), .wr_data(wr_data), .count_o(count_o),
        .mode_o(mode_o), .irq(irq)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge(logic t, logic wc, logic wm, logic [31:0] d);
        logic        matched;
        logic [31:0] up;
        logic        moving;
        matched = 0;
        moving  = t && (m_mode != 2'b00) && !m_halt;
        up      = m_cnt + 1;
        if (moving && up[27:0] == m_per) matched = 1;
        if (wm) m_ip = m_ip && d[28];
        if (matched && m_ie) m_ip = 1;
        if (wc) begin
            m_cnt = d; m_halt = 0;
        end else begin
            if (moving) m_cnt = (matched && m_mode == 2'b01) ? 32'd0 : up;
            if (wm) m_halt = 0;
            else if (matched && m_mode == 2'b10) m_halt = 1;
        end
        if (wm) begin
            m_mode = d[31:30]; m_ie = d[29]; m_per = d[27:0];
        end
    endtask

    task automatic step(string tag, logic t, logic wc, logic wm, logic [31:0] d);
        tick_en = t; cnt_wr = wc; mode_wr = wm; wr_data = d;
        @(posedge clk);
        model_edge(t, wc, wm, d);
        @(negedge clk);
        tick_en = 0; cnt_wr = 0; mode_wr = 0; wr_data = '0;
        check(tag, "count", count_o, m_cnt);
        check(tag, "mode", mode_o, {m_mode, m_ie, m_ip, m_per});
        check(tag, "irq", {31'd0, irq}, {31'd0, m_ip & m_ie});
    endtask

    task automatic ticks(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 1, 0, 0, '0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1", "count", count_o, 32'd0);
        check("R1", "mode", mode_o, 32'd0);
        check("R1", "irq", {31'd0, irq}, 32'd0);

        // R2 R4: continuous mode, period 5, enable on
        step("R11", 0, 0, 1, 32'hE000_0005);
        check("R11", "readback", mode_o, 32'hE000_0005);
        ticks("R2", 4);
        check("R2", "count after 4", count_o, 32'd4);
        step("R4", 1, 0, 0, '0);
        check("R4", "irq at match", {31'd0, irq}, 32'd1);
        step("R2", 0, 0, 0, '0);
        check("R2", "hold no tick", count_o, 32'd5);

        // R5: sticky pending
        step("R5", 0, 0, 1, 32'hF000_0005);
        check("R5", "write1 keeps", {31'd0, mode_o[28]}, 32'd1);
        step("R5", 0, 0, 1, 32'hE000_0005);
        check("R5", "write0 clears", {31'd0, mode_o[28]}, 32'd0);
        step("R5", 0, 0, 1, 32'hD000_0005);
        check("R5", "write1 no set", {31'd0, mode_o[28]}, 32'd0);

        // R6: off mode holds
        step("R6", 0, 0, 1, 32'h2000_0003);
        ticks("R6", 4);
        check("R6", "off hold", count_o, 32'd5);

        // R7: restart, period 3
        step("R7", 0, 1, 1, 32'h6000_0003);
        check("R7", "loaded", count_o, 32'h6000_0003);
        step("R7", 0, 1, 0, 32'd0);
        ticks("R7", 3);
        check("R7", "cleared at match", count_o, 32'd0);
        ticks("R7", 2);
        check("R7", "counts on", count_o, 32'd2);

        // R8: one-shot, period 4, enable off
        step("R8", 0, 0, 1, 32'h8000_0004);
        step("R8", 0, 1, 0, 32'd0);
        ticks("R8", 6);
        check("R8", "held at period", count_o, 32'd4);
        check("R4", "no pend when disabled", {31'd0, mode_o[28]}, 32'd0);
        step("R8", 0, 1, 0, 32'd1);
        ticks("R8", 1);
        check("R8", "resumes after write", count_o, 32'd2);

        // R3: upper bits ignored
        step("R3", 0, 0, 1, 32'hE000_0003);
        step("R3", 0, 1, 0, 32'h7000_0002);
        ticks("R3", 1);
        check("R3", "match upper set", {31'd0, mode_o[28]}, 32'd1);
        check("R3", "continues", count_o, 32'h7000_0003);

        // R9: continuous wrap, period 0
        step("R9", 0, 0, 1, 32'hE000_0000);
        step("R9", 0, 1, 0, 32'hFFFF_FFFE);
        ticks("R9", 2);
        check("R9", "wrapped", count_o, 32'd0);
        check("R9", "pend at wrap", {31'd0, irq}, 32'd1);
        ticks("R9", 1);
        check("R9", "after wrap", count_o, 32'd1);

        // R10: write wins over restart clear
        step("R10", 0, 0, 1, 32'h4000_0002);
        step("R10", 0, 1, 0, 32'd1);
        step("R10", 1, 1, 0, 32'h55);
        check("R10", "write wins", count_o, 32'h55);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule